// File: doc/BRIEF.md
# Extended-Data-Out DRAM Device Controller with Burst Column Counter

This block is the control side of an extended-data-out DRAM device, clocked by a fast internal clock that samples the active-low row strobe, column strobe, write enable and output enable pins. A fall of the row strobe either opens a row, with the row taken from the multiplexed address pins, or starts a column-before-row refresh. Each fall of the column strobe inside an open row writes the input data or reads a word into an output latch. The latched read word stays on the data pins after the column strobe rises. It is replaced only by the next column access, or cleared once both strobes are high.

A refresh runs when the column strobe is already low as the row strobe falls. It ignores the address pins. An internal row counter selects the row, and the block reports that row on a one-cycle refresh strobe. A hidden refresh leaves the column strobe low across a row-strobe high pulse, so the last read word stays on the pins during the refresh. With burst mode enabled, only the first column strobe of a group of four takes the address pins. The next three strobes take columns from an on-chip counter that wraps inside an aligned group of four. A small synchronous RAM stands in for the cell array.

The controller has three states. ST_IDLE means the row strobe is high. ST_ROW_OPEN means a normal row is open. ST_REFRESH means a refresh cycle is in progress. There are four transitions. ST_IDLE goes to ST_ROW_OPEN when the row strobe is sampled low with the column strobe high. ST_IDLE goes to ST_REFRESH when the row strobe is sampled low with the column strobe low. ST_ROW_OPEN returns to ST_IDLE when the row strobe is sampled high, and ST_REFRESH returns to ST_IDLE the same way.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset, dout_oe and rfsh_stb are low, dout is zero and the controller is in ST_IDLE.
- R2: When ras_n is sampled low in ST_IDLE with cas_n high, addr[RAW-1:0] is latched as the open row, and it does not change while ras_n stays low.
- R3: On the first clock that samples cas_n low (after high) in ST_ROW_OPEN with we_n low, din is stored at the open row and selected column, and the output latch is invalidated.
- R4: On such a clock with we_n high, the word at the open row and selected column is loaded into the output latch, and it is visible on dout from the following clock.
- R5: dout_oe is high only while the output latch is valid, oe_n is low and we_n is high. Whenever dout_oe is low, dout is zero.
- R6: The output latch keeps its word after cas_n rises. It changes only on the next column access, and it is invalidated on any clock that samples ras_n and cas_n both high.
- R7: When ras_n is sampled low in ST_IDLE with cas_n low, a refresh starts. The address pins are ignored, rfsh_stb pulses for exactly one cycle, rfsh_row shows the refresh counter value, and the counter then increments.
- R8: The refresh counter runs 0, 1, ..., ROWS-1 and then wraps to 0, with ROWS = 2**RAW.
- R9: A refresh cycle changes neither the array contents nor the output latch.
- R10: Hidden refresh works as follows. If ras_n rises while cas_n is held low after a read and then falls again, a refresh runs and the read word stays driven on dout throughout.
- R11: With burst_en high, the first column strobe of a group takes addr[CAW-1:0]. The next three column strobes ignore addr and use the base column plus 1, 2 and 3.
- R12: Burst columns wrap inside the aligned group of four: the two low column bits roll over, and the upper column bits stay those of the base.
- R13: With burst_en low, every column strobe takes its column from addr[CAW-1:0].
- R14: A rise of ras_n ends any partial burst, so the first column strobe after the next row opens takes addr again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_en | input | 1 | Burst mode select: four columns per group |
| addr | input | AW | Multiplexed row/column address, AW = max(RAW, CAW) |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not driven |
| dout_oe | output | 1 | Read data drive enable |
| rfsh_stb | output | 1 | One-cycle pulse at the start of a refresh |
| rfsh_row | output | RAW | Row refreshed by the current refresh |

## Verification
The bench builds the block with its defaults of 8 rows, 8 columns and 8-bit words. With this size every array location can be written and read back in a few hundred cycles. The refresh counter also wraps after only eight refresh cycles. A four-beat burst fits twice inside a row, so both a burst starting mid-group, which needs the rollover, and an aligned burst are reachable with real data.

// File: rtl/edo_pkg.sv
package edo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ROW_OPEN = 2'd1,
        ST_REFRESH  = 2'd2
    } edo_state_t;
endpackage

// File: rtl/edo_cell_ram.sv
// Stand-in cell array: synchronous write, registered read that holds its word.
module edo_cell_ram #(
    parameter int DW  = 8,
    parameter int RAW = 3,
    parameter int CAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [RAW-1:0] row,
    input  logic [CAW-1:0] col,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);
    localparam int DEPTH = 1 << (RAW + CAW);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[{row, col}] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= cells[{row, col}];
        end
    end
endmodule

// File: rtl/edo_col_gen.sv
// Column source: address pins or the on-chip burst counter.
module edo_col_gen #(
    parameter int CAW       = 3,
    parameter int BURST_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         step,
    input  logic                         burst_en,
    input  logic [CAW-1:0]               addr_col,
    output logic [CAW-1:0]               col,
    output logic [$clog2(BURST_LEN)-1:0] beat
);
    localparam int BW = $clog2(BURST_LEN);

    logic [CAW-1:0] base_q;
    logic [BW-1:0]  beat_q;
    logic           take_pins;
    logic [BW-1:0]  low_bits;

    assign take_pins = (beat_q == '0) || !burst_en;
    assign low_bits  = base_q[BW-1:0] + beat_q;

    generate
        if (CAW > BW) begin : g_hi
            assign col = take_pins ? addr_col : {base_q[CAW-1:BW], low_bits};
        end else begin : g_lo
            assign col = take_pins ? addr_col : low_bits;
        end
    endgenerate

    assign beat = beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (step) begin
            if (take_pins) begin
                base_q <= addr_col;
                beat_q <= burst_en ? BW'(1) : '0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/edo_rfsh_ctr.sv
// Refresh row counter, wraps at the row count.
module edo_rfsh_ctr #(
    parameter int RAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    output logic [RAW-1:0] row
);
    localparam int ROWS = 1 << RAW;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= (row == RAW'(ROWS - 1)) ? '0 : row + 1'b1;
        end
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
    parameter int DW        = 8,
    parameter int RAW       = 3,
    parameter int CAW       = 3,
    parameter int BURST_LEN = 4,
    localparam int AW       = (RAW > CAW) ? RAW : CAW,
    localparam int BW       = $clog2(BURST_LEN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ras_n,
    input  logic           cas_n,
    input  logic           we_n,
    input  logic           oe_n,
    input  logic           burst_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout,
    output logic           dout_oe,
    output logic           rfsh_stb,
    output logic [RAW-1:0] rfsh_row
);
    import edo_pkg::*;

    edo_state_t     state_q, state_d;
    logic           cas_q;
    logic           cas_fall;
    logic           row_ld, rf_go, access, burst_clr;
    logic           wr_en, rd_en;
    logic [RAW-1:0] row_q;
    logic [CAW-1:0] col_w;
    logic [BW-1:0]  beat_w;
    logic [RAW-1:0] ctr_row;
    logic [DW-1:0]  rdata;
    logic           valid_q;

    assign cas_fall = cas_q && !cas_n;

    // next state and per-cycle strobes
    always_comb begin
        state_d   = state_q;
        row_ld    = 1'b0;
        rf_go     = 1'b0;
        access    = 1'b0;
        burst_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!ras_n) begin
                    if (!cas_n) begin
                        state_d = ST_REFRESH;
                        rf_go   = 1'b1;
                    end else begin
                        state_d = ST_ROW_OPEN;
                        row_ld  = 1'b1;
                    end
                end
            end
            ST_ROW_OPEN: begin
                if (ras_n) begin
                    state_d   = ST_IDLE;
                    burst_clr = 1'b1;
                end else if (cas_fall) begin
                    access = 1'b1;
                end
            end
            ST_REFRESH: begin
                if (ras_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign wr_en = access && !we_n;
    assign rd_en = access && we_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cas_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cas_q   <= cas_n;
        end
    end

    // registered outputs and latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            valid_q  <= 1'b0;
            rfsh_stb <= 1'b0;
            rfsh_row <= '0;
        end else begin
            rfsh_stb <= rf_go;
            if (rf_go) begin
                rfsh_row <= ctr_row;
            end
            if (row_ld) begin
                row_q <= addr[RAW-1:0];
            end
            if (rd_en) begin
                valid_q <= 1'b1;
            end else if (wr_en || (ras_n && cas_n)) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign dout_oe = valid_q && !oe_n && we_n;
    assign dout    = dout_oe ? rdata : '0;

    edo_col_gen #(.CAW(CAW), .BURST_LEN(BURST_LEN)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (burst_clr),
        .step     (access),
        .burst_en (burst_en),
        .addr_col (addr[CAW-1:0]),
        .col      (col_w),
        .beat     (beat_w)
    );

    edo_rfsh_ctr #(.RAW(RAW)) u_rfsh (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rf_go),
        .row   (ctr_row)
    );

    edo_cell_ram #(.DW(DW), .RAW(RAW), .CAW(CAW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .row   (row_q),
        .col   (col_w),
        .wdata (din),
        .rdata (rdata)
    );
endmodule

// File: rtl/edo_dram_chk.sv
module edo_dram_chk #(
    parameter int DW  = 8,
    parameter int RAW = 3,
    parameter int BW  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cas_n,
    input edo_pkg::edo_state_t state_q,
    input logic [RAW-1:0]      row_q,
    input logic                rd_en,
    input logic [DW-1:0]       rdata,
    input logic [BW-1:0]       beat_w,
    input logic                rfsh_stb,
    input logic [RAW-1:0]      rfsh_row
);
    import edo_pkg::*;

    logic           seen_q;
    logic [RAW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (rfsh_stb) begin
            seen_q <= 1'b1;
            last_q <= rfsh_row;
        end
    end

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROW_OPEN && $past(state_q) == ST_ROW_OPEN) |-> $stable(row_q)); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata)); // R6
    AST_RFSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_stb |=> !rfsh_stb); // R7
    AST_RFSH_CAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_stb |-> !$past(cas_n)); // R7
    AST_RFSH_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_stb && seen_q) |-> rfsh_row == RAW'(last_q + 1'b1)); // R8
    AST_BURST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ROW_OPEN) |-> beat_w == '0); // R14
endmodule

bind edo_dram_ctrl edo_dram_chk #(.DW(DW), .RAW(RAW), .BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_n    (cas_n),
    .state_q  (state_q),
    .row_q    (row_q),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .beat_w   (beat_w),
    .rfsh_stb (rfsh_stb),
    .rfsh_row (rfsh_row)
);

// File: tb/edo_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb_top;
    localparam int DW   = 8;
    localparam int RAW  = 3;
    localparam int CAW  = 3;
    localparam int AW   = 3;
    localparam int ROWS = 8;
    localparam int COLS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, burst_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_oe, rfsh_stb;
    logic [RAW-1:0] rfsh_row;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    edo_dram_ctrl #(.DW(DW), .RAW(RAW), .CAW(CAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .burst_en(burst_en), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row)
    );

    // behavioural reference model
    logic [DW-1:0] mem [ROWS*COLS];
    int  m_state = 0;   // 0 idle, 1 row open, 2 refresh
    bit  m_cas_prev = 1;
    int  m_row = 0, m_base = 0, m_beat = 0, m_ctr = 0, m_rrow = 0;
    bit  m_valid = 0, m_stb = 0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk) begin
        int col;
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_cas_prev = 1; m_row = 0; m_base = 0; m_beat = 0;
            m_ctr = 0; m_rrow = 0; m_valid = 0; m_stb = 0; m_data = '0;
        end else begin
            m_stb = 0;
            if (m_state == 0) begin
                if (!ras_n) begin
                    if (!cas_n) begin
                        m_state = 2; m_stb = 1; m_rrow = m_ctr; m_ctr = (m_ctr + 1) % ROWS;
                    end else begin
                        m_state = 1; m_row = addr % ROWS;
                    end
                end
            end else if (m_state == 1) begin
                if (ras_n) begin
                    m_state = 0; m_beat = 0; m_base = 0;
                end else if (m_cas_prev && !cas_n) begin
                    if (m_beat == 0 || !burst_en) begin
                        col = addr % COLS;
                        m_base = col;
                        m_beat = burst_en ? 1 : 0;
                    end else begin
                        col = (m_base & ~3) | ((m_base + m_beat) & 3);
                        m_beat = (m_beat + 1) % 4;
                    end
                    if (!we_n) begin
                        mem[m_row*COLS + col] = din;
                        m_valid = 0;
                    end else begin
                        m_data = mem[m_row*COLS + col];
                        m_valid = 1;
                    end
                end
            end else begin
                if (ras_n) m_state = 0;
            end
            if (ras_n && cas_n) m_valid = 0;
            m_cas_prev = cas_n;
        end
    end

    // compare every clock, 1 ns after the edge
    always @(posedge clk) begin
        bit e_oe;
        logic [DW-1:0] e_dout;
        #1;
        e_oe   = m_valid && !oe_n && we_n;
        e_dout = e_oe ? m_data : '0;
        checks++;
        if (dout_oe !== e_oe || dout !== e_dout) begin
            errors++;
            $display("FAIL %s: dout_oe=%0b dout=%h expected dout_oe=%0b dout=%h at cycle %0d",
                     tag, dout_oe, dout, e_oe, e_dout, cycles);
        end
        checks++;
        if (rfsh_stb !== m_stb || (m_stb && rfsh_row !== RAW'(m_rrow))) begin
            errors++;
            $display("FAIL %s: rfsh_stb=%0b rfsh_row=%0d expected rfsh_stb=%0b rfsh_row=%0d at cycle %0d",
                     tag, rfsh_stb, rfsh_row, m_stb, m_rrow, cycles);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_row(input int r);
        addr = AW'(r); cas_n = 1; ras_n = 0; tick(1);
    endtask

    task automatic close_row();
        cas_n = 1; ras_n = 1; we_n = 1; tick(1);
    endtask

    task automatic cas_wr(input int c, input logic [DW-1:0] d);
        addr = AW'(c); din = d; we_n = 0; cas_n = 0; tick(1);
        cas_n = 1; tick(1); we_n = 1;
    endtask

    task automatic cas_rd(input int c, input int hold);
        addr = AW'(c); we_n = 1; cas_n = 0; tick(1);
        cas_n = 1; tick(hold);
    endtask

    task automatic cbr();
        cas_n = 0; tick(1);
        addr = AW'($urandom_range(0, 7)); ras_n = 0; tick(2);
        ras_n = 1; tick(1); cas_n = 1; tick(1);
    endtask

    function automatic logic [DW-1:0] pat(input int r, input int c);
        return DW'((r * 16 + c) ^ 8'h5A);
    endfunction

    // explicit port check tied to a requirement
    task automatic expect_out(input string t, input bit e_oe, input logic [DW-1:0] e_d);
        checks++;
        if (dout_oe !== e_oe || dout !== e_d) begin
            errors++;
            $display("FAIL %s: dout_oe=%0b dout=%h expected dout_oe=%0b dout=%h", t, dout_oe, dout, e_oe, e_d);
        end
    endtask

    initial begin : watchdog
        #(5ns * 20000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish before timeout");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        tag = "R1";
        expect_out("R1", 1'b0, '0);

        // R2 R3 R13: fill every location, pins give every column
        tag = "R3";
        burst_en = 0;
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) cas_wr(c, pat(r, c));
            close_row();
        end

        // R4 R6: read, then hold with cas high
        tag = "R4";
        open_row(3);
        cas_rd(5, 4);
        expect_out("R6", 1'b1, pat(3, 5));
        // R5: oe_n and we_n gate the drive without losing the word
        tag = "R5";
        oe_n = 1; tick(1);
        expect_out("R5", 1'b0, '0);
        oe_n = 0; we_n = 0; tick(1);
        expect_out("R5", 1'b0, '0);
        we_n = 1; tick(1);
        expect_out("R5", 1'b1, pat(3, 5));
        tag = "R13";
        cas_rd(2, 2);
        expect_out("R13", 1'b1, pat(3, 2));
        tag = "R6";
        close_row();
        tick(1);
        expect_out("R6", 1'b0, '0);

        // R7 R8: refresh wraps the counter
        tag = "R8";
        for (int i = 0; i < 11; i++) cbr();

        // R9: contents survive refresh
        tag = "R9";
        open_row(6);
        cas_rd(1, 1);
        expect_out("R9", 1'b1, pat(6, 1));
        close_row();

        // R10: hidden refresh keeps the read word driven
        tag = "R10";
        open_row(2);
        addr = 3'd4; we_n = 1; cas_n = 0; tick(2);
        ras_n = 1; tick(1);
        ras_n = 0; addr = 3'd7; tick(2);
        expect_out("R10", 1'b1, pat(2, 4));
        ras_n = 1; tick(1);
        expect_out("R10", 1'b1, pat(2, 4));
        cas_n = 1; tick(2);

        // R11 R12: burst read from mid-group base, addr ignored after first
        tag = "R12";
        burst_en = 1;
        open_row(1);
        cas_rd(6, 1);
        expect_out("R11", 1'b1, pat(1, 6));
        cas_rd(0, 1);
        expect_out("R12", 1'b1, pat(1, 7));
        cas_rd(0, 1);
        expect_out("R12", 1'b1, pat(1, 4));
        cas_rd(0, 1);
        expect_out("R12", 1'b1, pat(1, 5));
        // burst write from an aligned base
        tag = "R11";
        cas_wr(0, 8'hA0);
        cas_wr(7, 8'hA1);
        cas_wr(7, 8'hA2);
        cas_wr(7, 8'hA3);
        // R14: partial burst, then reopen
        tag = "R14";
        cas_rd(2, 1);
        close_row();
        open_row(1);
        cas_rd(3, 1);
        expect_out("R14", 1'b1, 8'hA3);
        close_row();
        burst_en = 0;
        open_row(1);
        cas_rd(1, 1);
        expect_out("R11", 1'b1, 8'hA1);
        close_row();
        tick(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule